// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block holds recently used page table entries so that a virtual page number can be turned into a physical page number and its permission bits without going to memory. The virtual page number is split in two. The low bits select one set, and the upper bits are compared against the tags of every way in that set. Each line carries a valid flag, a tag and the whole entry: the physical page number and the permission field.

The lookup is evaluated combinationally from the request, and the result is registered, so the response appears one cycle after the request. On a miss, logic outside the block resolves the translation and then writes it in through the fill port. A fill goes first into a line whose tag already matches, then into a free way, and only then replaces a way chosen by a round-robin pointer kept for each set. A flush input empties the whole cache in one cycle. Walking the page table and checking permissions are done elsewhere.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, every lookup misses until a fill has been made.
- R2: The set index is `lkp_vpn[3:0]` and the tag is `lkp_vpn[19:4]`. A lookup hits only when a valid line in the indexed set holds an equal tag, so a different tag in the same set misses.
- R3: `rsp_valid` is `lkp_valid` delayed by one cycle. On a hit, `rsp_ppn` and `rsp_perm` return the stored entry in that cycle. On a miss, both are zero.
- R4: A fill written on one clock edge is seen by a lookup issued in the following cycle.
- R5: Up to 4 distinct tags that share a set stay resident together, because a fill uses a free way before it evicts anything.
- R6: When a set is full and the fill tag is new, the set's round-robin pointer chooses the victim. The pointer starts at way 0 and advances by one after each such eviction, so ways are replaced in the order they were filled.
- R7: A fill whose tag is already in the indexed set overwrites that line, and a later lookup returns the new entry.
- R8: A flush invalidates every line in one cycle. It wins over a fill in the same cycle, and that fill is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_vpn | input | 20 | Virtual page number to translate |
| fill_en | input | 1 | Write one entry |
| fill_vpn | input | 20 | Virtual page number of the entry being written |
| fill_ppn | input | 20 | Physical page number to store |
| fill_perm | input | 4 | Permission bits to store |
| flush | input | 1 | Invalidate all lines |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Physical page number on a hit, zero on a miss |
| rsp_perm | output | 4 | Permission bits on a hit, zero on a miss |

## Verification
The bench fills a single set with four tags and then with a fifth and a sixth. A design that evicts before it uses free ways, or that moves its pointer in the wrong order, loses the wrong page, and a lookup then misses where it should hit or hits where it should miss. Refilling a tag that is already present must return the new frame; a design that writes a duplicate returns the stale one. A flush issued in the same cycle as a fill must discard the fill, and two tags in the same set must not alias, which catches a design that matches on the index alone.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      VIC_MATCH  = 2'd0,
      VIC_FREE   = 2'd1,
      VIC_ROTATE = 2'd2
   } victim_kind_e;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
   parameter int TAG_W = 16,
   parameter int WAYS  = 4
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
   input  logic [WAYS-1:0]            way_valid,
   input  logic [TAG_W-1:0]           req_tag,
   output logic [WAYS-1:0]            hit_vec
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tags[w] == req_tag);
   end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
   import tlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]  match_vec,
   input  logic [WAYS-1:0]  valid_vec,
   input  logic [WAY_W-1:0] rr_ptr,
   output logic [WAY_W-1:0] way,
   output victim_kind_e     kind
);
   logic [WAY_W-1:0] free_way, match_way;
   logic             any_free, any_match;

   always_comb begin
      free_way  = '0;
      match_way = '0;
      any_free  = 1'b0;
      any_match = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_vec[w]) begin
            free_way = WAY_W'(w);
            any_free = 1'b1;
         end
         if (match_vec[w]) begin
            match_way = WAY_W'(w);
            any_match = 1'b1;
         end
      end
      if (any_match) begin
         way  = match_way;
         kind = VIC_MATCH;
      end else if (any_free) begin
         way  = free_way;
         kind = VIC_FREE;
      end else begin
         way  = rr_ptr;
         kind = VIC_ROTATE;
      end
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import tlb_pkg::*;
#(
   parameter int VPN_W    = 20,
   parameter int PPN_W    = 20,
   parameter int PERM_W   = 4,
   parameter int SET_BITS = 4,
   parameter int WAYS     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lkp_valid,
   input  logic [VPN_W-1:0]  lkp_vpn,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              flush,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic [PERM_W-1:0] rsp_perm
);
   localparam int SETS  = 1 << SET_BITS;
   localparam int TAG_W = VPN_W - SET_BITS;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int LINES = SETS * WAYS;

   if (SET_BITS < 1 || SET_BITS >= VPN_W) begin : g_bad_index
      $error("SET_BITS must leave at least one tag bit");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end

   logic [WAYS-1:0]              valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
   logic [WAYS-1:0][PPN_W-1:0]   ppn_q   [SETS];
   logic [WAYS-1:0][PERM_W-1:0]  perm_q  [SETS];
   logic [WAY_W-1:0]             rr_q    [SETS];
   logic [LINES-1:0]             valid_flat;

   for (genvar s = 0; s < SETS; s++) begin : g_flat
      assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
   end

   // lookup side
   logic [SET_BITS-1:0] lk_idx;
   logic [TAG_W-1:0]    lk_tag;
   logic [WAYS-1:0]     lk_hit_vec;
   logic [PPN_W-1:0]    lk_ppn;
   logic [PERM_W-1:0]   lk_perm;

   assign lk_idx = lkp_vpn[SET_BITS-1:0];
   assign lk_tag = lkp_vpn[VPN_W-1:SET_BITS];

   tlb_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lkp_match (
      .way_tags (tag_q[lk_idx]),
      .way_valid(valid_q[lk_idx]),
      .req_tag  (lk_tag),
      .hit_vec  (lk_hit_vec)
   );

   always_comb begin
      lk_ppn  = '0;
      lk_perm = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (lk_hit_vec[w]) begin
            lk_ppn  = ppn_q[lk_idx][w];
            lk_perm = perm_q[lk_idx][w];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_ppn   <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lkp_valid;
         rsp_hit   <= lkp_valid && (|lk_hit_vec);
         rsp_ppn   <= (lkp_valid && (|lk_hit_vec)) ? lk_ppn  : '0;
         rsp_perm  <= (lkp_valid && (|lk_hit_vec)) ? lk_perm : '0;
      end
   end

   // fill side
   logic [SET_BITS-1:0] fl_idx;
   logic [TAG_W-1:0]    fl_tag;
   logic [WAYS-1:0]     fl_match_vec;
   logic [WAY_W-1:0]    fl_way;
   victim_kind_e        fl_kind;
   logic                fl_write;

   assign fl_idx   = fill_vpn[SET_BITS-1:0];
   assign fl_tag   = fill_vpn[VPN_W-1:SET_BITS];
   assign fl_write = fill_en && !flush;

   tlb_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_fill_match (
      .way_tags (tag_q[fl_idx]),
      .way_valid(valid_q[fl_idx]),
      .req_tag  (fl_tag),
      .hit_vec  (fl_match_vec)
   );

   tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .match_vec(fl_match_vec),
      .valid_vec(valid_q[fl_idx]),
      .rr_ptr   (rr_q[fl_idx]),
      .way      (fl_way),
      .kind     (fl_kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            rr_q[s]    <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
         end
      end else if (fill_en) begin
         valid_q[fl_idx][fl_way] <= 1'b1;
         if (fl_kind == VIC_ROTATE) begin
            rr_q[fl_idx] <= rr_q[fl_idx] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fl_write) begin
         tag_q[fl_idx][fl_way]  <= fl_tag;
         ppn_q[fl_idx][fl_way]  <= fill_ppn;
         perm_q[fl_idx][fl_way] <= fill_perm;
      end
   end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4,
   parameter int WAYS   = 4,
   parameter int LINES  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lkp_valid,
   input logic              flush,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [PPN_W-1:0]  rsp_ppn,
   input logic [PERM_W-1:0] rsp_perm,
   input logic [WAYS-1:0]   lk_hit_vec,
   input logic [LINES-1:0]  valid_flat
);
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_valid |=> rsp_valid);  // R3
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> !rsp_valid);  // R3
   AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);  // R3
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0));  // R3
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_flat == '0));  // R8
   AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec));  // R7
   AST_NO_HIT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush) && lkp_valid) |=> !rsp_hit);  // R1
endmodule

bind xlat_tlb tlb_checker #(
   .PPN_W (PPN_W),
   .PERM_W(PERM_W),
   .WAYS  (WAYS),
   .LINES (LINES)
) u_tlb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lkp_valid (lkp_valid),
   .flush     (flush),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_ppn   (rsp_ppn),
   .rsp_perm  (rsp_perm),
   .lk_hit_vec(lk_hit_vec),
   .valid_flat(valid_flat)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 47;
   localparam int NV = 13;
   // {op[1:0], vpn[19:0], ppn[19:0], perm[3:0], hit}; op 0=lookup 1=fill 2=flush
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'd0, 20'h12345, 20'h00000, 4'h0, 1'b0},
      {2'd1, 20'h12345, 20'h00ABC, 4'h5, 1'b0},
      {2'd0, 20'h12345, 20'h00ABC, 4'h5, 1'b1},
      {2'd0, 20'h22345, 20'h00000, 4'h0, 1'b0},
      {2'd1, 20'h22345, 20'h00DEF, 4'hA, 1'b0},
      {2'd0, 20'h22345, 20'h00DEF, 4'hA, 1'b1},
      {2'd0, 20'h12345, 20'h00ABC, 4'h5, 1'b1},
      {2'd0, 20'h12346, 20'h00000, 4'h0, 1'b0},
      {2'd1, 20'h12346, 20'h11111, 4'h3, 1'b0},
      {2'd0, 20'h12346, 20'h11111, 4'h3, 1'b1},
      {2'd2, 20'h00000, 20'h00000, 4'h0, 1'b0},
      {2'd0, 20'h12345, 20'h00000, 4'h0, 1'b0},
      {2'd0, 20'h12346, 20'h00000, 4'h0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lkp_valid = 1'b0;
   logic [19:0] lkp_vpn = '0;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic [3:0]  fill_perm = '0;
   logic        flush = 1'b0;
   logic        rsp_valid, rsp_hit;
   logic [19:0] rsp_ppn;
   logic [3:0]  rsp_perm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_tlb i_xlat_tlb (
      .clk(clk), .rst_n(rst_n),
      .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
      .flush(flush),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_lookup(input string req, input logic [19:0] vpn, input logic hit,
                            input logic [19:0] ppn, input logic [3:0] perm);
      @(negedge clk);
      lkp_valid = 1'b1;
      lkp_vpn   = vpn;
      @(negedge clk);
      lkp_valid = 1'b0;
      chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(req, "rsp_hit",   32'(rsp_hit),   32'(hit));
      chk(req, "rsp_ppn",   32'(rsp_ppn),   32'(ppn));
      chk(req, "rsp_perm",  32'(rsp_perm),  32'(perm));
   endtask

   task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                          input logic [3:0] perm, input logic with_flush);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
      flush = with_flush;
      @(negedge clk);
      fill_en = 1'b0; flush = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and R3 idle response
      chk("R1", "rsp_hit after reset", 32'(rsp_hit), 32'd0);
      chk("R3", "rsp_valid idle", 32'(rsp_valid), 32'd0);

      // table walk: R1 R2 R3 R4 R8
      for (int i = 0; i < NV; i++) begin
         case (VEC[i][46:45])
            2'd0: do_lookup("R2/R4 table", VEC[i][44:25], VEC[i][0], VEC[i][24:5], VEC[i][4:1]);
            2'd1: do_fill(VEC[i][44:25], VEC[i][24:5], VEC[i][4:1], 1'b0);
            default: do_flush();
         endcase
      end

      // R5: four tags share set 9
      for (int k = 1; k <= 4; k++) do_fill({16'(k), 4'h9}, 20'h00100 + 20'(k), 4'h1, 1'b0);
      for (int k = 1; k <= 4; k++) do_lookup("R5", {16'(k), 4'h9}, 1'b1, 20'h00100 + 20'(k), 4'h1);

      // R6: round-robin replacement from way 0
      do_fill(20'h00059, 20'h00105, 4'h1, 1'b0);
      do_lookup("R6", 20'h00019, 1'b0, 20'h0, 4'h0);
      do_lookup("R6", 20'h00029, 1'b1, 20'h00102, 4'h1);
      do_lookup("R6", 20'h00059, 1'b1, 20'h00105, 4'h1);
      do_fill(20'h00069, 20'h00106, 4'h1, 1'b0);
      do_lookup("R6", 20'h00029, 1'b0, 20'h0, 4'h0);
      do_lookup("R6", 20'h00039, 1'b1, 20'h00103, 4'h1);
      do_lookup("R6", 20'h00069, 1'b1, 20'h00106, 4'h1);

      // R7: refill of a resident tag overwrites it
      do_fill(20'h00A03, 20'h00200, 4'h1, 1'b0);
      do_fill(20'h00A03, 20'h00201, 4'h2, 1'b0);
      do_lookup("R7", 20'h00A03, 1'b1, 20'h00201, 4'h2);
      do_fill(20'h00B03, 20'h00202, 4'h3, 1'b0);
      do_fill(20'h00C03, 20'h00203, 4'h3, 1'b0);
      do_fill(20'h00D03, 20'h00204, 4'h3, 1'b0);
      do_lookup("R7", 20'h00A03, 1'b1, 20'h00201, 4'h2);
      do_lookup("R7", 20'h00D03, 1'b1, 20'h00204, 4'h3);

      // R8: flush wins over a fill in the same cycle
      do_fill(20'h00E07, 20'h00300, 4'h7, 1'b1);
      do_lookup("R8", 20'h00E07, 1'b0, 20'h0, 4'h0);
      do_lookup("R8", 20'h00A03, 1'b0, 20'h0, 4'h0);
      do_lookup("R8", 20'h00069, 1'b0, 20'h0, 4'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule